// File: doc/BRIEF.md
# Internal Data Space Access Unit

This block serves the operand accesses of a small 8-bit controller to its internal data space. It holds a 128-byte internal RAM and a few special function registers (SFRs). It turns an 8-bit operand field into a physical target according to the addressing mode the decoder presents. The modes are a working register of the selected bank, a direct byte address, a pointer held in one of the first two working registers, and a bit address. It then performs a byte read, a byte write, or a single-bit read-modify-write on that target.

Byte accesses answer in the cycle after the request. A bit operation is atomic. In the request cycle the block reads the target byte into a holding register. In the following cycle it writes the modified byte back, while `busy` is high. It returns the old bit, so a test-and-clear sequence needs no second request. Indirect pointers that land in the upper half of the space are reported as range errors and never touch an SFR.

Top module: `idata_access_unit`

## Requirements
- R1: In register mode (`mode`=0) the target is RAM byte `bank_sel`*8 + `addr[2:0]`.
- R2: In direct mode (`mode`=1) addresses 00H–7FH select RAM and 80H–FFH select SFRs. Implemented SFRs sit at 80H, 88H, 90H and 98H. Any other SFR address reads 00H and ignores writes.
- R3: In indirect mode (`mode`=2) `addr[0]` picks R0 or R1 of the selected bank, and the byte held there is the RAM address used.
- R4: An indirect access whose pointer is 80H or above returns `range_err`=1 with `rd_data`=00H and writes nothing.
- R5: A byte request (`mode`≠3) gives `resp_valid` for one cycle on the next clock. `rd_data` carries the target contents before the access, and with `wr_en`=1 `wr_data` is stored.
- R6: In bit mode (`mode`=3) a bit address below 80H selects bit `addr[2:0]` of RAM byte 20H + `addr[6:3]`. An address of 80H or above selects bit `addr[2:0]` of the SFR at `addr` AND F8H.
- R7: `bit_op` encodings are 0 test, 1 set, 2 clear, 3 complement and 4 test-and-clear, and codes 5–7 act as test. Only the addressed bit may change.
- R8: Every bit response reports the bit value from before the operation on `bit_out`. Test-and-clear returns the old value and leaves the bit 0. Byte responses give `bit_out`=0.
- R9: A bit request raises `busy` for exactly the next cycle and gives `resp_valid` in the cycle after that. `rd_data` then holds the byte before modification.
- R10: A request presented while `busy` is high is ignored.
- R11: After reset `busy` and `resp_valid` are low and all RAM bytes and SFRs read 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| mode | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| addr | input | 8 | Address, register index or bit address |
| bank_sel | input | 2 | Working register bank |
| wr_en | input | 1 | Byte write for modes 0–2 |
| wr_data | input | 8 | Byte write data |
| bit_op | input | 3 | Bit operation code |
| busy | output | 1 | Bit write-back cycle in progress |
| resp_valid | output | 1 | Response strobe |
| rd_data | output | 8 | Target byte before the access |
| bit_out | output | 1 | Old bit value of a bit operation |
| range_err | output | 1 | Indirect pointer out of range |

## Verification
The hardest case is a request that arrives during the write-back cycle of a bit operation. The bench reaches it by keeping `req_valid` high across the edge after the bit request, with a conflicting byte write to the same byte. It then reads that byte back to show that only the bit operation took effect. Out-of-range indirect accesses need a pointer register first loaded with a value of 80H or above through register mode. The bench follows that write with an indirect write and reads back the SFR that the pointer would have hit.

// File: rtl/idu_pkg.sv
// Package: shared widths, mode and bit-operation encodings, and the
// resolved-target record passed between the address stage and the datapath.
package idu_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    typedef enum logic [1:0] {
        AM_REG = 2'd0,
        AM_DIR = 2'd1,
        AM_IND = 2'd2,
        AM_BIT = 2'd3
    } am_e;

    typedef enum logic [2:0] {
        BO_TEST = 3'd0,
        BO_SET  = 3'd1,
        BO_CLR  = 3'd2,
        BO_CPL  = 3'd3,
        BO_TCLR = 3'd4
    } bop_e;

    typedef struct packed {
        logic          is_ram;
        logic          is_sfr;
        logic          err;
        logic [AW-1:0] byte_addr;
        logic [2:0]    bit_idx;
    } tgt_t;
endpackage

// File: rtl/idu_addr_resolve.sv
// Address resolver: maps mode + operand field (+ pointer byte) onto a RAM
// byte, an SFR byte or an error. Purely combinational.
// Assumes the pointer byte has already been read from the selected bank.
module idu_addr_resolve
    import idu_pkg::*;
#(
    parameter logic [AW-1:0] BITRAM_BASE = 8'h20
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    bank,
    input  logic [AW-1:0] ptr,
    output tgt_t          tgt
);
    // Decode the operand field per addressing mode.
    always_comb begin
        tgt = '0;
        case (am_e'(mode))
            AM_REG: begin
                tgt.is_ram    = 1'b1;
                tgt.byte_addr = {3'b000, bank, addr[2:0]};
            end
            AM_DIR: begin
                tgt.byte_addr = addr;
                tgt.is_ram    = ~addr[AW-1];
                tgt.is_sfr    = addr[AW-1];
            end
            AM_IND: begin
                tgt.byte_addr = ptr;
                tgt.err       = ptr[AW-1];
                tgt.is_ram    = ~ptr[AW-1];
            end
            default: begin
                tgt.bit_idx = addr[2:0];
                if (addr[AW-1]) begin
                    tgt.is_sfr    = 1'b1;
                    tgt.byte_addr = {addr[AW-1:3], 3'b000};
                end else begin
                    tgt.is_ram    = 1'b1;
                    tgt.byte_addr = BITRAM_BASE + {4'b0000, addr[6:3]};
                end
            end
        endcase
    end
endmodule

// File: rtl/idu_ram.sv
// Internal RAM: flop array, two asynchronous read ports (pointer and data),
// one synchronous write port. Synchronous reset clears every byte.
module idu_ram #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    // Storage update: clear on reset, else single-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/idu_sfr_bank.sv
// SFR bank: COUNT byte registers at BASE + k*STRIDE. Unmapped addresses
// read zero and drop writes. Assumes STRIDE keeps addresses distinct.
module idu_sfr_bank #(
    parameter int            COUNT  = 4,
    parameter logic [7:0]    BASE   = 8'h80,
    parameter int            STRIDE = 8,
    parameter int            DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    waddr,
    input  logic [DW-1:0] wdata,
    input  logic [7:0]    raddr,
    output logic [DW-1:0] rdata
);
    logic [COUNT-1:0] hit_w;
    logic [COUNT-1:0] hit_r;
    logic [DW-1:0]    rd_vec [COUNT];

    for (genvar k = 0; k < COUNT; k++) begin : g_sfr
        localparam logic [7:0] ADR = 8'(int'(BASE) + k * STRIDE);
        logic [DW-1:0] val;
        assign hit_w[k] = we && (waddr == ADR);
        assign hit_r[k] = (raddr == ADR);
        // One register: reset to zero, load on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)        val <= '0;
            else if (hit_w[k]) val <= wdata;
        end
        assign rd_vec[k] = hit_r[k] ? val : '0;
    end

    // Read mux: OR of the gated register values.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < COUNT; k++) rdata = rdata | rd_vec[k];
    end

    AST_SFR_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_w)); // R2
endmodule

// File: rtl/idu_bit_seq.sv
// Bit sequencer: on start, captures the target byte and the operation; in
// the following cycle (busy) presents the modified byte for write-back and
// the old bit. Assumes start is never raised while busy.
module idu_bit_seq
    import idu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  tgt_t          tgt,
    input  logic [2:0]    op,
    input  logic [DW-1:0] byte_in,
    output logic          busy,
    output logic          wb_ram,
    output logic          wb_sfr,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data,
    output logic [DW-1:0] old_byte,
    output logic          old_bit
);
    typedef enum logic {SQ_IDLE = 1'b0, SQ_WB = 1'b1} sq_e;

    sq_e           state;
    logic [DW-1:0] hold;
    logic [2:0]    h_idx;
    logic [2:0]    h_op;
    logic          h_ram;
    logic          h_sfr;
    logic [AW-1:0] h_addr;
    logic [DW-1:0] sel;
    logic          modify;

    // Capture on start, release after the write-back cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            hold   <= '0;
            h_idx  <= '0;
            h_op   <= '0;
            h_ram  <= 1'b0;
            h_sfr  <= 1'b0;
            h_addr <= '0;
        end else if (state == SQ_IDLE) begin
            if (start) begin
                state  <= SQ_WB;
                hold   <= byte_in;
                h_idx  <= tgt.bit_idx;
                h_op   <= op;
                h_ram  <= tgt.is_ram;
                h_sfr  <= tgt.is_sfr;
                h_addr <= tgt.byte_addr;
            end
        end else begin
            state <= SQ_IDLE;
        end
    end

    // Modified byte for the selected operation.
    always_comb begin
        sel     = DW'(1) << h_idx;
        modify  = 1'b1;
        wb_data = hold;
        case (bop_e'(h_op))
            BO_SET:          wb_data = hold | sel;
            BO_CLR, BO_TCLR: wb_data = hold & ~sel;
            BO_CPL:          wb_data = hold ^ sel;
            default:         modify  = 1'b0;
        endcase
    end

    assign busy     = (state == SQ_WB);
    assign wb_ram   = busy && modify && h_ram;
    assign wb_sfr   = busy && modify && h_sfr;
    assign wb_addr  = h_addr;
    assign old_byte = hold;
    assign old_bit  = hold[h_idx];

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R9
    AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(wb_data ^ old_byte) <= 1)); // R7
endmodule

// File: rtl/idata_access_unit.sv
// Internal data space access unit (top). Resolves the operand address,
// performs byte reads/writes in one cycle and bit read-modify-write over
// two cycles. Assumes the requester observes busy before issuing again;
// requests seen while busy are dropped.
module idata_access_unit
    import idu_pkg::*;
#(
    parameter int          RAM_DEPTH   = 128,
    parameter int          SFR_COUNT   = 4,
    parameter logic [7:0]  SFR_BASE    = 8'h80,
    parameter int          SFR_STRIDE  = 8,
    parameter logic [7:0]  BITRAM_BASE = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] mode,
    input  logic [7:0] addr,
    input  logic [1:0] bank_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [2:0] bit_op,
    output logic       busy,
    output logic       resp_valid,
    output logic [7:0] rd_data,
    output logic       bit_out,
    output logic       range_err
);
    localparam int IW = $clog2(RAM_DEPTH);

    tgt_t          tgt;
    logic [DW-1:0] ptr_byte;
    logic [DW-1:0] ram_rd;
    logic [DW-1:0] sfr_rd;
    logic [DW-1:0] tgt_byte;
    logic          accept;
    logic          byte_go;
    logic          byte_we;
    logic          bit_go;
    logic          seq_wb_ram;
    logic          seq_wb_sfr;
    logic [AW-1:0] seq_addr;
    logic [DW-1:0] seq_data;
    logic [DW-1:0] seq_old_byte;
    logic          seq_old_bit;
    logic          ram_we;
    logic [IW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata;
    logic          sfr_we;
    logic [AW-1:0] sfr_waddr;
    logic [DW-1:0] sfr_wdata;
    logic [IW-1:0] ptr_idx;

    assign ptr_idx = IW'({bank_sel, 2'b00, addr[0]});

    idu_ram #(.DEPTH(RAM_DEPTH), .DW(DW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (ptr_idx),
        .rdata_a (ptr_byte),
        .raddr_b (tgt.byte_addr[IW-1:0]),
        .rdata_b (ram_rd)
    );

    idu_addr_resolve #(.BITRAM_BASE(BITRAM_BASE)) u_res (
        .mode (mode),
        .addr (addr),
        .bank (bank_sel),
        .ptr  (ptr_byte),
        .tgt  (tgt)
    );

    idu_sfr_bank #(
        .COUNT(SFR_COUNT), .BASE(SFR_BASE), .STRIDE(SFR_STRIDE), .DW(DW)
    ) u_sfr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sfr_we),
        .waddr (sfr_waddr),
        .wdata (sfr_wdata),
        .raddr (tgt.byte_addr),
        .rdata (sfr_rd)
    );

    // Target byte as seen before this access.
    assign tgt_byte = tgt.is_ram ? ram_rd : (tgt.is_sfr ? sfr_rd : '0);

    assign accept  = req_valid && !busy;
    assign byte_go = accept && (am_e'(mode) != AM_BIT);
    assign bit_go  = accept && (am_e'(mode) == AM_BIT);
    assign byte_we = byte_go && wr_en && !tgt.err;

    idu_bit_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (bit_go),
        .tgt      (tgt),
        .op       (bit_op),
        .byte_in  (tgt_byte),
        .busy     (busy),
        .wb_ram   (seq_wb_ram),
        .wb_sfr   (seq_wb_sfr),
        .wb_addr  (seq_addr),
        .wb_data  (seq_data),
        .old_byte (seq_old_byte),
        .old_bit  (seq_old_bit)
    );

    // Write-port steering: bit write-back owns the ports while busy.
    always_comb begin
        ram_we    = seq_wb_ram || (byte_we && tgt.is_ram);
        ram_waddr = seq_wb_ram ? seq_addr[IW-1:0] : tgt.byte_addr[IW-1:0];
        ram_wdata = seq_wb_ram ? seq_data : wr_data;
        sfr_we    = seq_wb_sfr || (byte_we && tgt.is_sfr);
        sfr_waddr = seq_wb_sfr ? seq_addr : tgt.byte_addr;
        sfr_wdata = seq_wb_sfr ? seq_data : wr_data;
    end

    // Response registers for byte and bit completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            rd_data    <= '0;
            bit_out    <= 1'b0;
            range_err  <= 1'b0;
        end else begin
            resp_valid <= byte_go || busy;
            range_err  <= byte_go && tgt.err;
            bit_out    <= busy && seq_old_bit;
            if (busy)         rd_data <= seq_old_byte;
            else if (byte_go) rd_data <= tgt.err ? '0 : tgt_byte;
        end
    end

    AST_ERR_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> resp_valid); // R4
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && am_e'(mode) == AM_IND && ptr_byte[7]) |-> (!ram_we && !sfr_we)); // R4
    AST_BYTE_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_go |=> (resp_valid && !busy)); // R5
    AST_BIT_RESP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> resp_valid); // R9
    AST_BIT_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bit_go |=> busy); // R9
endmodule

// File: tb/tb_idata_access_unit.sv
`timescale 1ns/1ps
module tb_idata_access_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] mode = '0;
    logic [7:0] addr = '0;
    logic [1:0] bank_sel = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] bit_op = '0;
    logic       busy, resp_valid, bit_out, range_err;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    idata_access_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .addr(addr), .bank_sel(bank_sel), .wr_en(wr_en), .wr_data(wr_data),
        .bit_op(bit_op), .busy(busy), .resp_valid(resp_valid),
        .rd_data(rd_data), .bit_out(bit_out), .range_err(range_err)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;
    string cur_tag = "R11";

    // Behavioural reference state.
    logic [7:0] m_ram [128];
    logic [7:0] m_sfr [256];
    bit         m_busy;
    int         p_kind, p_a, p_idx, p_op;
    logic [7:0] p_old;
    string      p_tag;
    bit         e_valid, e_bit, e_err, e_busy;
    logic [7:0] e_rd;
    string      e_tag = "R11";

    function automatic bit sfr_impl(int a);
        return a >= 128 && ((a - 128) % 8) == 0 && ((a - 128) / 8) < 4;
    endfunction

    // Reference model: advances on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) m_ram[i] = 8'h00;
            for (int i = 0; i < 256; i++) m_sfr[i] = 8'h00;
            m_busy = 0; e_valid = 0; e_bit = 0; e_err = 0; e_busy = 0; e_rd = 0;
        end else begin
            e_valid = 0; e_err = 0; e_bit = 0;
            if (m_busy) begin
                logic [7:0] nb;
                nb = p_old;
                case (p_op)
                    1: nb[p_idx] = 1'b1;
                    2, 4: nb[p_idx] = 1'b0;
                    3: nb[p_idx] = ~nb[p_idx];
                    default: ;
                endcase
                if (p_kind == 1) m_ram[p_a] = nb;
                else if (p_kind == 2 && sfr_impl(p_a)) m_sfr[p_a] = nb;
                e_valid = 1; e_rd = p_old; e_bit = p_old[p_idx]; e_tag = p_tag;
                m_busy = 0;
            end else if (req_valid) begin
                int a, ta, kind, idx;
                logic [7:0] cur;
                a = int'(addr); idx = a % 8; kind = 1; ta = 0;
                case (mode)
                    2'd0: ta = int'(bank_sel) * 8 + a % 8;
                    2'd1: begin ta = a; kind = (a < 128) ? 1 : 2; end
                    2'd2: begin
                        ta = int'(m_ram[int'(bank_sel) * 8 + (a & 1)]);
                        kind = (ta < 128) ? 1 : 0;
                    end
                    default: begin
                        if (a < 128) ta = 32 + a / 8;
                        else begin ta = a & 'hF8; kind = 2; end
                    end
                endcase
                cur = (kind == 1) ? m_ram[ta] :
                      ((kind == 2 && sfr_impl(ta)) ? m_sfr[ta] : 8'h00);
                if (mode == 2'd3) begin
                    p_kind = kind; p_a = ta; p_idx = idx; p_op = int'(bit_op);
                    p_old = cur; p_tag = cur_tag; m_busy = 1;
                end else begin
                    e_valid = 1; e_err = (kind == 0); e_rd = cur;
                    e_tag = (kind == 0) ? "R4" : cur_tag;
                    if (wr_en) begin
                        if (kind == 1) m_ram[ta] = wr_data;
                        else if (kind == 2 && sfr_impl(ta)) m_sfr[ta] = wr_data;
                    end
                end
            end
            e_busy = m_busy;
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp, string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Comparison on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk("busy", {7'b0, busy}, {7'b0, e_busy}, "R9");
            chk("resp_valid", {7'b0, resp_valid}, {7'b0, e_valid}, e_valid ? e_tag : "R5");
            if (e_valid) begin
                chk("rd_data", rd_data, e_rd, e_tag);
                chk("bit_out", {7'b0, bit_out}, {7'b0, e_bit}, "R8");
                chk("range_err", {7'b0, range_err}, {7'b0, e_err}, "R4");
            end
        end
    end

    task automatic do_req(logic [1:0] m, logic [7:0] a, logic [1:0] b, logic w,
                          logic [7:0] d, logic [2:0] op, string tg);
        @(negedge clk);
        req_valid = 1'b1; mode = m; addr = a; bank_sel = b; wr_en = w;
        wr_data = d; bit_op = op; cur_tag = tg;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R11: reset contents
        do_req(2'd1, 8'h00, 2'd0, 0, 0, 0, "R11");
        do_req(2'd1, 8'h7F, 2'd0, 0, 0, 0, "R11");
        do_req(2'd1, 8'h98, 2'd0, 0, 0, 0, "R11");
        // R5 / R2: direct RAM and SFR writes with read-back
        do_req(2'd1, 8'h45, 2'd0, 1, 8'h3C, 0, "R5");
        do_req(2'd1, 8'h45, 2'd0, 1, 8'hC3, 0, "R5");
        do_req(2'd1, 8'h45, 2'd0, 0, 0, 0, "R5");
        do_req(2'd1, 8'h80, 2'd0, 1, 8'h11, 0, "R2");
        do_req(2'd1, 8'h90, 2'd0, 1, 8'h5A, 0, "R2");
        do_req(2'd1, 8'h81, 2'd0, 1, 8'hEE, 0, "R2");
        do_req(2'd1, 8'h81, 2'd0, 0, 0, 0, "R2");
        do_req(2'd1, 8'h90, 2'd0, 0, 0, 0, "R2");
        // R1: register mode across banks
        do_req(2'd0, 8'h03, 2'd2, 1, 8'h77, 0, "R1");
        do_req(2'd0, 8'hFB, 2'd3, 1, 8'h99, 0, "R1");
        do_req(2'd1, 8'h13, 2'd0, 0, 0, 0, "R1");
        do_req(2'd1, 8'h1B, 2'd0, 0, 0, 0, "R1");
        // R3: indirect through R0 and R1 of bank 1
        do_req(2'd0, 8'h00, 2'd1, 1, 8'h50, 0, "R3");
        do_req(2'd0, 8'h01, 2'd1, 1, 8'h90, 0, "R3");
        do_req(2'd2, 8'h00, 2'd1, 1, 8'hA5, 0, "R3");
        do_req(2'd1, 8'h50, 2'd0, 0, 0, 0, "R3");
        // R4: out-of-range pointer, SFR 90H must stay 5AH
        do_req(2'd2, 8'h01, 2'd1, 1, 8'h00, 0, "R4");
        do_req(2'd1, 8'h90, 2'd0, 0, 0, 0, "R4");
        // R6 / R7 / R8: bit operations on RAM byte 21H bit 3
        do_req(2'd3, 8'h0B, 2'd0, 0, 0, 3'd1, "R6");
        do_req(2'd1, 8'h21, 2'd0, 0, 0, 0, "R6");
        do_req(2'd3, 8'h0B, 2'd0, 0, 0, 3'd3, "R7");
        do_req(2'd3, 8'h0B, 2'd0, 0, 0, 3'd3, "R7");
        do_req(2'd3, 8'h0B, 2'd0, 0, 0, 3'd4, "R8");
        do_req(2'd3, 8'h0B, 2'd0, 0, 0, 3'd0, "R8");
        do_req(2'd3, 8'h7F, 2'd0, 0, 0, 3'd1, "R6");
        do_req(2'd3, 8'h7F, 2'd0, 0, 0, 3'd6, "R7");
        do_req(2'd3, 8'h7E, 2'd0, 0, 0, 3'd2, "R7");
        do_req(2'd1, 8'h2F, 2'd0, 0, 0, 0, "R7");
        // R6: SFR bits (90H bit 3) and unimplemented SFR bit
        do_req(2'd3, 8'h93, 2'd0, 0, 0, 3'd3, "R6");
        do_req(2'd1, 8'h90, 2'd0, 0, 0, 0, "R6");
        do_req(2'd3, 8'hA1, 2'd0, 0, 0, 3'd1, "R6");
        do_req(2'd1, 8'hA0, 2'd0, 0, 0, 0, "R6");
        // R10: request held during write-back must be dropped
        @(negedge clk);
        req_valid = 1'b1; mode = 2'd3; addr = 8'h00; bit_op = 3'd1; cur_tag = "R10";
        @(negedge clk);
        mode = 2'd1; addr = 8'h20; wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        do_req(2'd1, 8'h20, 2'd0, 0, 0, 0, "R10");
        // Random mix across all modes
        for (int k = 0; k < 600; k++) begin
            logic [1:0] m;
            string tg;
            m = 2'($urandom % 4);
            tg = (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R7";
            do_req(m, 8'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
                   3'($urandom), tg);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule